// File: doc/BRIEF.md
# NCO Phase and Frequency Control

This block is the phase generator of a numerically controlled oscillator. Each clock it advances a 32-bit phase accumulator by the sum of a center frequency word and an offset frequency word. It then adds a 16-bit phase offset to the upper half of the accumulator and presents the result as a registered 32-bit sine/cosine argument. A separate lookup stage consumes that argument. Frequency words and the phase offset arrive over a 16-bit write bus with a 2-bit address, an active-low select and a write strobe. Separate active-low enables, each registered once, then move the staged values into the working registers.

The modulator can reach the phase path in several ways. It can retune the offset word while the center word holds the carrier, or mask the offset path without losing the stored word. It can restart the accumulator from the frequency sum alone, add one extra count per clock, and freeze the accumulator. The phase offset can come from the bus or from a 2-bit quadrature code. A half-turn mode folds the argument into the first half circle. A registered active-low wrap flag marks every accumulator overflow.

The bus side is a two-state machine. BUS_IDLE moves to BUS_ARMED when select and strobe are both low. BUS_ARMED returns to BUS_IDLE on one of two transitions: "commit", when the strobe rises while select is still low, or "abandon", when select rises first. Only the commit transition writes. It writes the address and data sampled at that clock.

Top module: `nco_phase_ctrl`

## Requirements
- R1: After reset, phase_arg is 0 and wrap_n is 1 (inactive).
- R2: A bus write takes effect only on the commit transition (strobe sampled high one clock after select and strobe were both sampled low, with select still low). Address 0 stages the low 16 bits of the frequency word, address 1 stages the high 16 bits, and address 2 stages the phase input. A strobe with select high writes nothing, and neither does a select that rises before the strobe.
- R3: A commit to address 3 is accepted by the bus but changes none of the staged words, working registers or outputs.
- R4: Every control pin is captured by a register first. A working register loads at the second clock edge after its enable pin falls, and it reloads at every edge while its registered enable stays low.
- R5: While the registered accumulate enable is low, the accumulator adds (center + offset) mod 2^32 at every edge. phase_arg shows the accumulator one clock later.
- R6: While the registered accumulate enable is high, the accumulator and phase_arg hold, and wrap_n stays 1.
- R7: At an edge where the registered zero-feedback control is low, the accumulator takes the frequency sum plus carry-in only, and discards its previous value.
- R8: While the registered offset mask is low, the offset word adds nothing. The stored offset word is kept, so it counts again as soon as the mask is released.
- R9: While the registered carry input is low, each accumulation adds one extra count.
- R10: wrap_n is 0 for exactly the clock after an edge whose accumulator update passed 2^32. Overflow inside the frequency-word sum alone does not count.
- R11: The 16-bit phase register is added modulo 2^16 to bits 31..16 of the accumulator. Bits 15..0 pass through unchanged.
- R12: With the phase-source select low, the phase register loads the quadrature code mapped into bits 15..14, with zeros below. The mapping is 00→00 (0°), 01→01 (90°), 10→11 (270°) and 11→10 (180°). With the select high, it loads the staged phase input.
- R13: While the registered half-turn control is high, bit 31 of phase_arg is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs_n | input | 1 | Bus select, active low |
| bus_wr_n | input | 1 | Write strobe; the write commits when it rises |
| bus_addr | input | 2 | Staging target: 0 low word, 1 high word, 2 phase input, 3 no effect |
| bus_data | input | BUS_W | Write data |
| ctr_we_n | input | 1 | Center frequency load enable, active low |
| ofs_we_n | input | 1 | Offset frequency load enable, active low |
| ph_we_n | input | 1 | Phase register load enable, active low |
| acc_en_n | input | 1 | Accumulator clock enable, active low |
| acc_zero_n | input | 1 | Zero the accumulator feedback, active low |
| ofs_mask_n | input | 1 | Mask the offset contribution, active low |
| carry_in_n | input | 1 | Add one extra count, active low |
| ph_src_sel | input | 1 | Phase source: 1 staged input, 0 quadrature code |
| qpsk_code | input | 2 | Quadrature phase code |
| half_turn | input | 1 | Force argument bit 31 to 0 |
| phase_arg | output | 2*BUS_W | Registered sine/cosine argument |
| wrap_n | output | 1 | Registered accumulator overflow flag, active low |

## Verification
The accumulator is driven with several frequency sums, and each one separates a different fault. A quarter-turn step overflows on the fourth update and tests the wrap flag. A center-plus-offset sum, with the mask on and then off, tells a dropped offset apart from a cleared one. A near-full-scale center word makes the frequency adder overflow, which must not raise the wrap flag. Phase offsets are tried in three forms: a plain value, a value that overflows the upper half, and all four quadrature codes, which catch a plain binary mapping. Staged-but-ignored bus cycles (select high, abandoned strobe, address 3) are checked through a later reload, so any corruption of the staged words would show in the argument.

// File: rtl/nco_pkg.sv
package nco_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE  = 1'b0,
        BUS_ARMED = 1'b1
    } bus_state_t;

    localparam logic [1:0] ADDR_FREQ_LO = 2'd0;
    localparam logic [1:0] ADDR_FREQ_HI = 2'd1;
    localparam logic [1:0] ADDR_PHASE   = 2'd2;
    localparam logic [1:0] ADDR_SPARE   = 2'd3;

    typedef struct packed {
        logic       ctr_we_n;
        logic       ofs_we_n;
        logic       ph_we_n;
        logic       acc_en_n;
        logic       acc_zero_n;
        logic       ofs_mask_n;
        logic       carry_in_n;
        logic       ph_src_sel;
        logic       half_turn;
        logic [1:0] qpsk;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        ctr_we_n:   1'b1,
        ofs_we_n:   1'b1,
        ph_we_n:    1'b1,
        acc_en_n:   1'b1,
        acc_zero_n: 1'b1,
        ofs_mask_n: 1'b1,
        carry_in_n: 1'b1,
        ph_src_sel: 1'b0,
        half_turn:  1'b0,
        qpsk:       2'b00
    };

    // quarter-turn code: 0 deg, 90 deg, 270 deg, 180 deg
    function automatic logic [1:0] qpsk_map(input logic [1:0] code);
        logic [1:0] r;
        unique case (code)
            2'b00:   r = 2'b00;
            2'b01:   r = 2'b01;
            2'b10:   r = 2'b11;
            default: r = 2'b10;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nco_bus_port.sv
module nco_bus_port
    import nco_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] data,
    output logic [BUS_W-1:0] lo_q,
    output logic [BUS_W-1:0] hi_q,
    output logic [BUS_W-1:0] ph_in_q
);

    bus_state_t state_q, state_d;
    logic       commit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                if (!cs_n && !wr_n) state_d = BUS_ARMED;
            end
            BUS_ARMED: begin
                if (cs_n) begin
                    state_d = BUS_IDLE;        // abandon
                end else if (wr_n) begin
                    state_d = BUS_IDLE;        // commit
                    commit  = 1'b1;
                end
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    // outputs: staging registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            ph_in_q <= '0;
        end else if (commit) begin
            unique case (addr)
                ADDR_FREQ_LO: lo_q    <= data;
                ADDR_FREQ_HI: hi_q    <= data;
                ADDR_PHASE:   ph_in_q <= data;
                ADDR_SPARE:   ;
                default:      ;
            endcase
        end
    end

endmodule

// File: rtl/nco_ctrl_reg.sv
module nco_ctrl_reg
    import nco_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctr_we_n,
    input  logic       ofs_we_n,
    input  logic       ph_we_n,
    input  logic       acc_en_n,
    input  logic       acc_zero_n,
    input  logic       ofs_mask_n,
    input  logic       carry_in_n,
    input  logic       ph_src_sel,
    input  logic [1:0] qpsk_code,
    input  logic       half_turn,
    output ctrl_t      ctl_q
);

    ctrl_t ctl_d;

    always_comb begin
        ctl_d.ctr_we_n   = ctr_we_n;
        ctl_d.ofs_we_n   = ofs_we_n;
        ctl_d.ph_we_n    = ph_we_n;
        ctl_d.acc_en_n   = acc_en_n;
        ctl_d.acc_zero_n = acc_zero_n;
        ctl_d.ofs_mask_n = ofs_mask_n;
        ctl_d.carry_in_n = carry_in_n;
        ctl_d.ph_src_sel = ph_src_sel;
        ctl_d.half_turn  = half_turn;
        ctl_d.qpsk       = qpsk_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTRL_RESET;
        else        ctl_q <= ctl_d;
    end

endmodule

// File: rtl/nco_freq_acc.sv
module nco_freq_acc
    import nco_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctl,
    input  logic [ACC_W-1:0] word_in,
    output logic [ACC_W-1:0] ctr_q,
    output logic [ACC_W-1:0] ofs_q,
    output logic [ACC_W-1:0] freq_sum,
    output logic [ACC_W-1:0] acc_q,
    output logic             wrap_n
);

    logic [ACC_W-1:0] feedback;
    logic [ACC_W:0]   acc_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
            ofs_q <= '0;
        end else begin
            if (!ctl.ctr_we_n) ctr_q <= word_in;
            if (!ctl.ofs_we_n) ofs_q <= word_in;
        end
    end

    always_comb begin
        freq_sum = ctr_q + (ctl.ofs_mask_n ? ofs_q : '0);
        feedback = ctl.acc_zero_n ? acc_q : '0;
        acc_next = {1'b0, feedback} + {1'b0, freq_sum}
                 + {{ACC_W{1'b0}}, ~ctl.carry_in_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            wrap_n <= 1'b1;
        end else if (!ctl.acc_en_n) begin
            acc_q  <= acc_next[ACC_W-1:0];
            wrap_n <= ~acc_next[ACC_W];
        end else begin
            wrap_n <= 1'b1;
        end
    end

endmodule

// File: rtl/nco_phase_out.sv
module nco_phase_out
    import nco_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PH_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctl,
    input  logic [PH_W-1:0]  ph_in,
    input  logic [ACC_W-1:0] acc,
    output logic [ACC_W-1:0] arg_q
);

    localparam int LOW_W = ACC_W - PH_W;

    logic [PH_W-1:0]  ph_q;
    logic [PH_W-1:0]  ph_src;
    logic [PH_W-1:0]  top_sum;
    logic [ACC_W-1:0] arg_d;

    always_comb begin
        if (ctl.ph_src_sel) ph_src = ph_in;
        else                ph_src = {qpsk_map(ctl.qpsk), {(PH_W-2){1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            ph_q <= '0;
        else if (!ctl.ph_we_n) ph_q <= ph_src;
    end

    always_comb begin
        top_sum = acc[ACC_W-1:LOW_W] + ph_q;
        arg_d   = {top_sum, acc[LOW_W-1:0]};
        if (ctl.half_turn) arg_d[ACC_W-1] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arg_q <= '0;
        else        arg_q <= arg_d;
    end

endmodule

// File: rtl/nco_phase_ctrl.sv
module nco_phase_ctrl
    import nco_pkg::*;
#(
    parameter  int BUS_W = 16,
    localparam int ACC_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cs_n,
    input  logic             bus_wr_n,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_data,
    input  logic             ctr_we_n,
    input  logic             ofs_we_n,
    input  logic             ph_we_n,
    input  logic             acc_en_n,
    input  logic             acc_zero_n,
    input  logic             ofs_mask_n,
    input  logic             carry_in_n,
    input  logic             ph_src_sel,
    input  logic [1:0]       qpsk_code,
    input  logic             half_turn,
    output logic [ACC_W-1:0] phase_arg,
    output logic             wrap_n
);

    logic [BUS_W-1:0] lo_word;
    logic [BUS_W-1:0] hi_word;
    logic [BUS_W-1:0] ph_word;
    ctrl_t            ctl;
    logic [ACC_W-1:0] ctr_val;
    logic [ACC_W-1:0] ofs_val;
    logic [ACC_W-1:0] freq_sum;
    logic [ACC_W-1:0] acc_val;

    nco_bus_port #(.BUS_W(BUS_W)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (bus_cs_n),
        .wr_n    (bus_wr_n),
        .addr    (bus_addr),
        .data    (bus_data),
        .lo_q    (lo_word),
        .hi_q    (hi_word),
        .ph_in_q (ph_word)
    );

    nco_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctr_we_n   (ctr_we_n),
        .ofs_we_n   (ofs_we_n),
        .ph_we_n    (ph_we_n),
        .acc_en_n   (acc_en_n),
        .acc_zero_n (acc_zero_n),
        .ofs_mask_n (ofs_mask_n),
        .carry_in_n (carry_in_n),
        .ph_src_sel (ph_src_sel),
        .qpsk_code  (qpsk_code),
        .half_turn  (half_turn),
        .ctl_q      (ctl)
    );

    nco_freq_acc #(.ACC_W(ACC_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .word_in  ({hi_word, lo_word}),
        .ctr_q    (ctr_val),
        .ofs_q    (ofs_val),
        .freq_sum (freq_sum),
        .acc_q    (acc_val),
        .wrap_n   (wrap_n)
    );

    nco_phase_out #(.ACC_W(ACC_W), .PH_W(BUS_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .ph_in (ph_word),
        .acc   (acc_val),
        .arg_q (phase_arg)
    );

endmodule

// File: rtl/nco_phase_ctrl_chk.sv
module nco_phase_ctrl_chk
    import nco_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PH_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input ctrl_t            ctl,
    input logic [ACC_W-1:0] ctr_val,
    input logic [ACC_W-1:0] ofs_val,
    input logic [ACC_W-1:0] freq_sum,
    input logic [ACC_W-1:0] acc_val,
    input logic [ACC_W-1:0] phase_arg,
    input logic             wrap_n
);

    localparam int LOW_W = ACC_W - PH_W;

    // R6
    a_r6_hold_acc: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.acc_en_n |=> $stable(acc_val));

    // R6, R10
    a_r10_no_wrap_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.acc_en_n |=> wrap_n);

    // R4
    a_r4_ofs_keep: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ofs_we_n |=> $stable(ofs_val));

    // R5
    a_r5_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.acc_en_n && ctl.acc_zero_n && ctl.carry_in_n)
        |=> acc_val == $past(acc_val) + $past(freq_sum));

    // R7, R8
    a_r7_zero_fb_loads_center: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.acc_en_n && !ctl.acc_zero_n && ctl.carry_in_n && !ctl.ofs_mask_n)
        |=> acc_val == $past(ctr_val));

    // R11
    a_r11_low_half_passes: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> phase_arg[LOW_W-1:0] == $past(acc_val[LOW_W-1:0]));

    // R13
    a_r13_half_turn: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.half_turn |=> !phase_arg[ACC_W-1]);

endmodule

bind nco_phase_ctrl nco_phase_ctrl_chk #(.ACC_W(ACC_W), .PH_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .ctr_val   (ctr_val),
    .ofs_val   (ofs_val),
    .freq_sum  (freq_sum),
    .acc_val   (acc_val),
    .phase_arg (phase_arg),
    .wrap_n    (wrap_n)
);

// File: tb/tb_nco_phase_ctrl.sv
`timescale 1ns/1ps
module tb_nco_phase_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs_n = 1'b1;
    logic        bus_wr_n = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_data = 16'd0;
    logic        ctr_we_n = 1'b1;
    logic        ofs_we_n = 1'b1;
    logic        ph_we_n = 1'b1;
    logic        acc_en_n = 1'b1;
    logic        acc_zero_n = 1'b1;
    logic        ofs_mask_n = 1'b1;
    logic        carry_in_n = 1'b1;
    logic        ph_src_sel = 1'b1;
    logic [1:0]  qpsk_code = 2'd0;
    logic        half_turn = 1'b0;
    logic [31:0] phase_arg;
    logic        wrap_n;

    int n_total = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    typedef struct {
        int          at;
        bit          is_wrap;
        logic [31:0] exp;
        string       req;
    } exp_t;
    exp_t sbq[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nco_phase_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
        .bus_addr(bus_addr), .bus_data(bus_data), .ctr_we_n(ctr_we_n),
        .ofs_we_n(ofs_we_n), .ph_we_n(ph_we_n), .acc_en_n(acc_en_n),
        .acc_zero_n(acc_zero_n), .ofs_mask_n(ofs_mask_n), .carry_in_n(carry_in_n),
        .ph_src_sel(ph_src_sel), .qpsk_code(qpsk_code), .half_turn(half_turn),
        .phase_arg(phase_arg), .wrap_n(wrap_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops scoreboard items when their cycle arrives
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0 && sbq[0].at <= cyc) begin
                if (sbq[0].at < cyc) begin
                    check({sbq[0].req, " missed sample"}, 32'd0, 32'd1);
                end else if (sbq[0].is_wrap) begin
                    check({sbq[0].req, " wrap_n"}, {31'd0, wrap_n}, sbq[0].exp);
                end else begin
                    check({sbq[0].req, " phase_arg"}, phase_arg, sbq[0].exp);
                end
                void'(sbq.pop_front());
            end
        end
    endtask_dummy: begin end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_cycle(input logic cs, input logic [1:0] a, input logic [15:0] d);
        bus_cs_n = cs; bus_addr = a; bus_data = d; bus_wr_n = 1'b0;
        step();
        bus_wr_n = 1'b1;
        step();
        bus_cs_n = 1'b1;
    endtask

    task automatic set_word(input logic [31:0] w);
        bus_cycle(1'b0, 2'd0, w[15:0]);
        bus_cycle(1'b0, 2'd1, w[31:16]);
    endtask

    // sel: 0 center, 1 offset, 2 phase
    task automatic pulse_we(input int sel);
        if (sel == 0) ctr_we_n = 1'b0;
        else if (sel == 1) ofs_we_n = 1'b0;
        else ph_we_n = 1'b0;
        step();
        ctr_we_n = 1'b1; ofs_we_n = 1'b1; ph_we_n = 1'b1;
        step();
    endtask

    function automatic logic [31:0] exp_arg(input logic [31:0] a, input logic [15:0] ph);
        logic [15:0] top;
        top = a[31:16] + ph;
        return {top, a[15:0]};
    endfunction

    // driver: restart accumulator, push expected argument and wrap flag
    task automatic run_acc(input logic [31:0] fs, input bit cin, input logic [15:0] ph,
                           input int n, input string req);
        longint unsigned s;
        longint unsigned now_v;
        longint unsigned prev_v;
        int c1;
        exp_t it;
        s = longint'(fs) + longint'(cin);
        acc_en_n = 1'b0; acc_zero_n = 1'b0;
        step();
        c1 = cyc;
        acc_zero_n = 1'b1;
        for (int k = 1; k <= n; k++) begin
            now_v  = longint'(k) * s;
            prev_v = longint'(k - 1) * s;
            it.at = c1 + k; it.is_wrap = 1'b1; it.req = {req, " R10"};
            it.exp = ((now_v >> 32) != (prev_v >> 32)) ? 32'd0 : 32'd1;
            sbq.push_back(it);
            it.at = c1 + 1 + k; it.is_wrap = 1'b0; it.req = req;
            it.exp = exp_arg(now_v[31:0], ph);
            sbq.push_back(it);
        end
        repeat (n + 2) step();
    endtask

    initial begin
        logic [31:0] snap;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R1 reset arg", phase_arg, 32'd0);
        check("R1 reset wrap", {31'd0, wrap_n}, 32'd1);

        // R5 R7 R10: quarter-turn step wraps on the fourth update
        set_word(32'h4000_0000);
        pulse_we(0);
        run_acc(32'h4000_0000, 1'b0, 16'h0, 6, "R5 R7 quarter");

        // R5: center + offset, R2 low/high halves
        set_word(32'h0010_0000);
        pulse_we(1);
        set_word(32'h0100_0003);
        pulse_we(0);
        run_acc(32'h0110_0003, 1'b0, 16'h0, 4, "R5 R2 sum");

        // R8: mask then release
        ofs_mask_n = 1'b0; step();
        run_acc(32'h0100_0003, 1'b0, 16'h0, 3, "R8 masked");
        ofs_mask_n = 1'b1; step();
        run_acc(32'h0110_0003, 1'b0, 16'h0, 3, "R8 retained");

        // R9: carry in
        carry_in_n = 1'b0; step();
        run_acc(32'h0110_0003, 1'b1, 16'h0, 4, "R9 carry_in");
        carry_in_n = 1'b1; step();

        // R10: frequency adder overflow alone is not a wrap
        set_word(32'hFFFF_FFF0);
        pulse_we(0);
        run_acc(32'h000F_FFF0, 1'b0, 16'h0, 3, "R10 freq overflow");

        // R6: freeze
        acc_en_n = 1'b1;
        repeat (3) step();
        snap = phase_arg;
        repeat (3) step();
        check("R6 hold arg", phase_arg, snap);
        check("R6 hold wrap", {31'd0, wrap_n}, 32'd1);

        // R11: phase offset on upper half
        set_word(32'h0);
        pulse_we(1);
        set_word(32'h0000_8000);
        pulse_we(0);
        ph_src_sel = 1'b1;
        bus_cycle(1'b0, 2'd2, 16'h1234);
        pulse_we(2);
        run_acc(32'h0000_8000, 1'b0, 16'h1234, 4, "R11 offset");
        bus_cycle(1'b0, 2'd2, 16'hF000);
        pulse_we(2);
        set_word(32'h2000_0000);
        pulse_we(0);
        run_acc(32'h2000_0000, 1'b0, 16'hF000, 4, "R11 top wrap");

        // R12: quadrature codes with zero frequency
        set_word(32'h0);
        pulse_we(0);
        run_acc(32'h0, 1'b0, 16'hF000, 2, "R12 setup");
        ph_src_sel = 1'b0;
        qpsk_code = 2'b00; pulse_we(2); step();
        check("R12 code 00", phase_arg, 32'h0000_0000);
        qpsk_code = 2'b01; pulse_we(2); step();
        check("R12 code 01", phase_arg, 32'h4000_0000);
        qpsk_code = 2'b11; pulse_we(2); step();
        check("R12 code 11", phase_arg, 32'h8000_0000);
        qpsk_code = 2'b10; pulse_we(2); step();
        check("R12 code 10", phase_arg, 32'hC000_0000);

        // R13: half-turn
        half_turn = 1'b1; step(); step();
        check("R13 half on", phase_arg, 32'h4000_0000);
        half_turn = 1'b0; step(); step();
        check("R13 half off", phase_arg, 32'hC000_0000);

        // R4: continuous reload while enable held
        ph_src_sel = 1'b1;
        ph_we_n = 1'b0; step(); step();
        bus_cycle(1'b0, 2'd2, 16'h0A0A); step(); step();
        check("R4 reload 1", phase_arg, 32'h0A0A_0000);
        bus_cycle(1'b0, 2'd2, 16'h5A5A); step(); step();
        check("R4 reload 2", phase_arg, 32'h5A5A_0000);
        ph_we_n = 1'b1; step(); step();

        // R2 R3: ignored bus cycles, proven through reload
        bus_cycle(1'b1, 2'd2, 16'h1111);
        bus_cs_n = 1'b0; bus_addr = 2'd2; bus_data = 16'h2222; bus_wr_n = 1'b0;
        step();
        bus_cs_n = 1'b1; step();
        bus_wr_n = 1'b1; step();
        bus_cycle(1'b0, 2'd3, 16'hFFFF);
        pulse_we(2); step();
        check("R2 R3 phase input kept", phase_arg, 32'h5A5A_0000);
        pulse_we(0);
        run_acc(32'h0, 1'b0, 16'h5A5A, 2, "R3 freq word kept");

        repeat (2) step();
        if (sbq.size() != 0) check("scoreboard drained", sbq.size(), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule